// File: doc/BRIEF.md
# Frame-Synchronised Shadow Configuration Bank

This block keeps two copies of the configuration for a display pipe. One is a global video control word. The others are a small set of words for each of two overlay windows. Software writes over a simple register port, and every write lands in the front copy. The scan-out logic only ever sees the active copy, and the active copy changes only on the vertical sync pulse. A frame therefore always starts with a complete, consistent setup, never a half-written one.

A transfer is armed by an update-request bit. On the next vsync the global word is copied. Each window is copied too, unless its protect bit is set. A protected window that misses a transfer is marked as held. It is copied on the first vsync after its protect bit is cleared, and no new request is needed for that. The scan-out side receives the whole active copy, a per-window on flag, a registered copy of vsync and a one-cycle done pulse for every vsync that moved data.

Address map (word addresses):
- 0: global video control word.
- 1: protect word. Bit w protects window w.
- 2: update word. Bit 0 is the request. The upper bits are plain storage.
- 3: status word. Bit 0 shows a pending request. Bit 1+w shows that window w is held.
- 8 + 4·w + i: word i (0..3) of window w. Bit 0 of word 0 is the window on bit.

Top module: `shadow_regbank`

## Requirements
- R1: After synchronous reset, every front and active word, the protect bits, the request, the held flags, `rd_data`, `vsync_o`, `update_done_o` and `win_on_o` are zero.
- R2: A write stores into the front copy only. A read (`rd_en` high) returns the front copy of the addressed word on `rd_data` one clock later. The active outputs do not change because of a write.
- R3: On a clock where `vsync_i` is high and a request is pending, the global word and every unprotected window take their front values. The new values appear on the active outputs after that same edge.
- R4: A vsync with no pending request and no held window leaves every active output unchanged.
- R5: A window whose protect bit is set keeps its active words through a vsync. If a request was pending at that vsync, status bit 1+w becomes 1.
- R6: A held window whose protect bit is clear is copied at the next vsync even with no request pending, and its held bit then clears.
- R7: Writing the update word stores bits 31..1 as written. Writing 1 to bit 0 sets the request and writing 0 leaves it unchanged. The request clears at a vsync, unless a write setting it lands on that same clock, in which case it stays set.
- R8: Status bit 0 reads 1 exactly while a request is pending.
- R9: `win_on_o[w]` follows the active copy of bit 0 of window w word 0. Clearing that bit in the front copy turns the window off only at the following transfer.
- R10: `vsync_o` is `vsync_i` delayed by one clock. `update_done_o` is high for one clock after a vsync edge at which any word was copied, and low otherwise.
- R11: Reads of unmapped addresses (4..7 and 16..31) return zero, and writes to them change no readable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Registered read data, front copy |
| vsync_i | input | 1 | Vertical sync pulse, one clock wide |
| vsync_o | output | 1 | Registered vsync |
| update_done_o | output | 1 | Pulse: the last vsync moved data |
| act_glob_o | output | DATA_W | Active global control word |
| act_win_o | output | NUM_WIN*WIN_REGS*DATA_W | Active window words, window-major |
| win_on_o | output | NUM_WIN | Active on bit per window |

## Verification
A wrong protect decision or a stale held flag shows on the active outputs one clock after the vsync it should have affected. The status word exposes it on the next read. A request bit that fails to clear produces a spurious done pulse and an extra transfer at the following vsync. A transfer that happens outside vsync shows as an active word changing one clock after an ordinary write. The bench sweeps every protect pattern with and without a request, so each of these faults differs from the computed image within one frame step.

// File: rtl/shadow_regbank_pkg.sv
package shadow_regbank_pkg;

  localparam int unsigned ADR_GLOBAL   = 0;
  localparam int unsigned ADR_PROTECT  = 1;
  localparam int unsigned ADR_UPDATE   = 2;
  localparam int unsigned ADR_STATUS   = 3;
  localparam int unsigned ADR_WIN_BASE = 8;

  typedef struct packed {
    logic       hit;
    logic [7:0] win;
    logic [7:0] idx;
  } win_loc_t;

  // Map a word address onto (window, word) inside the window area.
  function automatic win_loc_t locate(input int unsigned addr,
                                      input int unsigned nwin,
                                      input int unsigned nregs,
                                      input int unsigned stride_lg);
    win_loc_t    r;
    int unsigned off;
    r = '0;
    if (addr >= ADR_WIN_BASE) begin
      off = addr - ADR_WIN_BASE;
      if ((off >> stride_lg) < nwin &&
          (off & ((32'd1 << stride_lg) - 1)) < nregs) begin
        r.hit = 1'b1;
        r.win = 8'(off >> stride_lg);
        r.idx = 8'(off & ((32'd1 << stride_lg) - 1));
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/shadow_front_bank.sv
module shadow_front_bank
  import shadow_regbank_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_REGS = 4,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [DATA_W-1:0]            prot_word_i,
  input  logic [DATA_W-1:0]            upd_word_i,
  input  logic [DATA_W-1:0]            stat_word_i,
  output logic [DATA_W-1:0]            front_glob_o,
  output logic [NUM_WIN*WIN_REGS*DATA_W-1:0] front_win_o,
  output logic [DATA_W-1:0]            rd_data
);

  localparam int unsigned STRIDE_LG = (WIN_REGS > 1) ? $clog2(WIN_REGS) : 1;
  localparam int unsigned WIN_IW    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int unsigned IDX_IW    = STRIDE_LG;

  logic [DATA_W-1:0] glob_q;
  logic [DATA_W-1:0] win_q [NUM_WIN][WIN_REGS];
  win_loc_t          wloc, rloc;
  logic [DATA_W-1:0] rd_next;

  always_comb wloc = locate(int'(wr_addr), NUM_WIN, WIN_REGS, STRIDE_LG);
  always_comb rloc = locate(int'(rd_addr), NUM_WIN, WIN_REGS, STRIDE_LG);

  always_ff @(posedge clk) begin
    if (rst)
      glob_q <= '0;
    else if (wr_en && wr_addr == ADDR_W'(ADR_GLOBAL))
      glob_q <= wr_data;
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    for (genvar i = 0; i < WIN_REGS; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)
          win_q[w][i] <= '0;
        else if (wr_en && wloc.hit && wloc.win == 8'(w) && wloc.idx == 8'(i))
          win_q[w][i] <= wr_data;
      end
      assign front_win_o[(w*WIN_REGS+i)*DATA_W +: DATA_W] = win_q[w][i];
    end
  end

  assign front_glob_o = glob_q;

  always_comb begin
    rd_next = '0;
    if (rloc.hit)
      rd_next = win_q[rloc.win[WIN_IW-1:0]][rloc.idx[IDX_IW-1:0]];
    else if (rd_addr == ADDR_W'(ADR_GLOBAL))
      rd_next = glob_q;
    else if (rd_addr == ADDR_W'(ADR_PROTECT))
      rd_next = prot_word_i;
    else if (rd_addr == ADDR_W'(ADR_UPDATE))
      rd_next = upd_word_i;
    else if (rd_addr == ADDR_W'(ADR_STATUS))
      rd_next = stat_word_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_next;
  end

  // R11: an unmapped write leaves the global front word alone
  p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ADDR_W'(ADR_GLOBAL)) |=> $stable(glob_q));

endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl
  import shadow_regbank_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_WIN = 2,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                vsync_i,
  output logic                glob_load_o,
  output logic [NUM_WIN-1:0]  win_load_o,
  output logic [NUM_WIN-1:0]  prot_o,
  output logic [DATA_W-1:0]   prot_word_o,
  output logic [DATA_W-1:0]   upd_word_o,
  output logic [DATA_W-1:0]   stat_word_o,
  output logic                vsync_o,
  output logic                done_o
);

  logic               upd_req_q;
  logic [DATA_W-2:0]  upd_rest_q;
  logic [NUM_WIN-1:0] prot_q, held_q;
  logic               vs_q, done_q;
  logic               wr_upd, wr_prot, req_set;

  assign wr_upd  = wr_en && wr_addr == ADDR_W'(ADR_UPDATE);
  assign wr_prot = wr_en && wr_addr == ADDR_W'(ADR_PROTECT);
  assign req_set = wr_upd && wr_data[0];

  assign glob_load_o = vsync_i && upd_req_q;
  assign win_load_o  = {NUM_WIN{vsync_i}} & ~prot_q &
                       ({NUM_WIN{upd_req_q}} | held_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q     <= '0;
      upd_rest_q <= '0;
      upd_req_q  <= 1'b0;
      held_q     <= '0;
      vs_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      if (wr_prot) prot_q <= wr_data[NUM_WIN-1:0];
      if (wr_upd)  upd_rest_q <= wr_data[DATA_W-1:1];
      if (req_set)      upd_req_q <= 1'b1;
      else if (vsync_i) upd_req_q <= 1'b0;
      if (vsync_i)
        held_q <= (held_q & ~win_load_o) | ({NUM_WIN{upd_req_q}} & prot_q);
      vs_q   <= vsync_i;
      done_q <= glob_load_o | (|win_load_o);
    end
  end

  assign prot_o      = prot_q;
  assign prot_word_o = DATA_W'(prot_q);
  assign upd_word_o  = {upd_rest_q, upd_req_q};
  assign stat_word_o = DATA_W'({held_q, upd_req_q});
  assign vsync_o     = vs_q;
  assign done_o      = done_q;

  // R7: request drops after a vsync unless re-armed on that clock
  p_req_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (vsync_i && !req_set) |=> !upd_req_q);

  // R10: a done pulse only ever follows a vsync
  p_done_cause_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(vsync_i));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R6: an unprotected held window is released by the vsync
    p_held_release_r6: assert property (@(posedge clk) disable iff (rst)
      (vsync_i && held_q[w] && !prot_q[w]) |=> !held_q[w]);
    // R5: a window only becomes held while it is protected
    p_held_needs_prot_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(held_q[w]) |-> $past(prot_q[w]));
  end

endmodule

// File: rtl/shadow_active_bank.sv
module shadow_active_bank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_REGS = 4
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               glob_load_i,
  input  logic [NUM_WIN-1:0]                 win_load_i,
  input  logic [DATA_W-1:0]                  front_glob_i,
  input  logic [NUM_WIN*WIN_REGS*DATA_W-1:0] front_win_i,
  output logic [DATA_W-1:0]                  act_glob_o,
  output logic [NUM_WIN*WIN_REGS*DATA_W-1:0] act_win_o,
  output logic [NUM_WIN-1:0]                 win_on_o
);

  localparam int unsigned WIN_BITS = WIN_REGS * DATA_W;

  always_ff @(posedge clk) begin
    if (rst)              act_glob_o <= '0;
    else if (glob_load_i) act_glob_o <= front_glob_i;
  end

  // R4: global word holds without a load
  p_glob_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !glob_load_i |=> $stable(act_glob_o));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst)
        act_win_o[w*WIN_BITS +: WIN_BITS] <= '0;
      else if (win_load_i[w])
        act_win_o[w*WIN_BITS +: WIN_BITS] <= front_win_i[w*WIN_BITS +: WIN_BITS];
    end
    assign win_on_o[w] = act_win_o[w*WIN_BITS];

    // R3: a load captures the front words present at the vsync edge
    p_win_copy_r3: assert property (@(posedge clk) disable iff (rst)
      win_load_i[w] |=> act_win_o[w*WIN_BITS +: WIN_BITS] ==
                        $past(front_win_i[w*WIN_BITS +: WIN_BITS]));
    // R4: without a load the window image is frozen
    p_win_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !win_load_i[w] |=> $stable(act_win_o[w*WIN_BITS +: WIN_BITS]));
  end

endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_WIN  = 2,
  parameter int unsigned WIN_REGS = 4,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               rd_en,
  input  logic [ADDR_W-1:0]                  rd_addr,
  output logic [DATA_W-1:0]                  rd_data,
  input  logic                               vsync_i,
  output logic                               vsync_o,
  output logic                               update_done_o,
  output logic [DATA_W-1:0]                  act_glob_o,
  output logic [NUM_WIN*WIN_REGS*DATA_W-1:0] act_win_o,
  output logic [NUM_WIN-1:0]                 win_on_o
);

  localparam int unsigned WIN_BITS = WIN_REGS * DATA_W;

  logic [DATA_W-1:0]          front_glob;
  logic [NUM_WIN*WIN_BITS-1:0] front_win;
  logic                       glob_load;
  logic [NUM_WIN-1:0]         win_load, prot;
  logic [DATA_W-1:0]          prot_word, upd_word, stat_word;

  shadow_xfer_ctrl #(.DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vsync_i(vsync_i), .glob_load_o(glob_load), .win_load_o(win_load),
    .prot_o(prot), .prot_word_o(prot_word), .upd_word_o(upd_word),
    .stat_word_o(stat_word), .vsync_o(vsync_o), .done_o(update_done_o));

  shadow_front_bank #(.DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_REGS(WIN_REGS),
                      .ADDR_W(ADDR_W)) u_front (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .prot_word_i(prot_word),
    .upd_word_i(upd_word), .stat_word_i(stat_word),
    .front_glob_o(front_glob), .front_win_o(front_win), .rd_data(rd_data));

  shadow_active_bank #(.DATA_W(DATA_W), .NUM_WIN(NUM_WIN), .WIN_REGS(WIN_REGS)) u_act (
    .clk(clk), .rst(rst), .glob_load_i(glob_load), .win_load_i(win_load),
    .front_glob_i(front_glob), .front_win_i(front_win),
    .act_glob_o(act_glob_o), .act_win_o(act_win_o), .win_on_o(win_on_o));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R5: a protected window keeps its image across the vsync
    p_protect_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (vsync_i && prot[w]) |=> $stable(act_win_o[w*WIN_BITS +: WIN_BITS]));
    // R9: a window only switches off right after a vsync
    p_off_at_vsync_r9: assert property (@(posedge clk) disable iff (rst)
      $fell(win_on_o[w]) |-> $past(vsync_i));
  end

  // R10: the vsync copy is exactly one clock late
  p_vsync_delay_r10: assert property (@(posedge clk) disable iff (rst)
    vsync_i |=> vsync_o);

endmodule

// File: tb/shadow_regbank_tb.sv
module shadow_regbank_tb_top;

  localparam int DW = 32;
  localparam int NW = 2;
  localparam int NR = 4;
  localparam int AW = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0, rd_en = 1'b0, vsync_i = 1'b0;
  logic [AW-1:0]     wr_addr = '0, rd_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic [DW-1:0]     rd_data, act_glob_o;
  logic [NW*NR*DW-1:0] act_win_o;
  logic [NW-1:0]     win_on_o;
  logic              vsync_o, update_done_o;

  always #4 clk = ~clk;

  shadow_regbank #(.DATA_W(DW), .NUM_WIN(NW), .WIN_REGS(NR), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .vsync_i(vsync_i),
    .vsync_o(vsync_o), .update_done_o(update_done_o), .act_glob_o(act_glob_o),
    .act_win_o(act_win_o), .win_on_o(win_on_o));

  // Spec image
  logic [DW-1:0] fr_g, ac_g;
  logic [DW-1:0] fr_w [NW][NR];
  logic [DW-1:0] ac_w [NW][NR];
  logic [NW-1:0] m_prot, m_held;
  logic          m_req;
  logic [DW-2:0] m_rest;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int waddr(input int w, input int i);
    return 8 + 4*w + i;
  endfunction

  function automatic logic [DW-1:0] exp_read(input int a);
    if (a == 0) return fr_g;
    if (a == 1) return DW'(m_prot);
    if (a == 2) return {m_rest, m_req};
    if (a == 3) return DW'({m_held, m_req});
    if (a >= 8 && a < 16) return fr_w[(a-8)/4][(a-8)%4];
    return '0;
  endfunction

  task automatic model_write(input int a, input logic [DW-1:0] d);
    if (a == 0) fr_g = d;
    else if (a == 1) m_prot = d[NW-1:0];
    else if (a == 2) begin m_rest = d[DW-1:1]; if (d[0]) m_req = 1'b1; end
    else if (a >= 8 && a < 16) fr_w[(a-8)/4][(a-8)%4] = d;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd_chk(input string tag, input int a);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rd_data, exp_read(a));
  endtask

  task automatic check_active(input string tag);
    chk({tag, " glob"}, act_glob_o, ac_g);
    for (int w = 0; w < NW; w++) begin
      for (int i = 0; i < NR; i++)
        chk($sformatf("%s w%0d i%0d", tag, w, i), act_win_o[(w*NR+i)*DW +: DW], ac_w[w][i]);
      chk($sformatf("%s R9 on w%0d", tag, w), DW'(win_on_o[w]), DW'(ac_w[w][0][0]));
    end
  endtask

  // vsync pulse, optionally with a write on the same clock
  task automatic vs(input bit with_wr, input int a, input logic [DW-1:0] d);
    logic exp_done;
    logic [NW-1:0] ld;
    ld = ~m_prot & ({NW{m_req}} | m_held);
    exp_done = m_req | (|ld);
    vsync_i = 1'b1;
    if (with_wr) begin wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; end
    @(posedge clk); @(negedge clk);
    vsync_i = 1'b0; wr_en = 1'b0;
    if (m_req) ac_g = fr_g;
    for (int w = 0; w < NW; w++)
      if (ld[w]) for (int i = 0; i < NR; i++) ac_w[w][i] = fr_w[w][i];
    m_held = (m_held & ~ld) | ({NW{m_req}} & m_prot);
    m_req = 1'b0;
    if (with_wr) model_write(a, d);
    chk("R10 vsync_o high", DW'(vsync_o), 1);
    chk("R10 done pulse", DW'(update_done_o), DW'(exp_done));
    check_active("R3 after vsync");
    @(posedge clk); @(negedge clk);
    chk("R10 vsync_o low", DW'(vsync_o), 0);
    chk("R10 done low", DW'(update_done_o), 0);
  endtask

  task automatic fill(input int seed);
    wr(0, DW'(32'h6000_0000 + seed * 32'h101));
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < NR; i++)
        wr(waddr(w, i), DW'(32'h1000_0000 * (w + 1) + seed * 32'h10 + i + ((seed + w) % 2 == 0 ? 1 : 0) * (i == 0 ? 1 : 0)) & ~DW'((i == 0 && (seed + w) % 2 != 0) ? 1 : 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    fr_g = '0; ac_g = '0; m_prot = '0; m_held = '0; m_req = 1'b0; m_rest = '0;
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < NR; i++) begin fr_w[w][i] = '0; ac_w[w][i] = '0; end

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset image
    check_active("R1 reset");
    chk("R1 rd_data", rd_data, 0);
    chk("R1 vsync_o", DW'(vsync_o), 0);
    chk("R1 done", DW'(update_done_o), 0);
    for (int a = 0; a < 16; a++) rd_chk("R1 reset read", a);

    // R2: writes go to front, active untouched
    fill(1);
    for (int a = 0; a < 16; a++) rd_chk("R2 readback", a);
    check_active("R2 active unchanged");

    // R4: vsync without request
    vs(0, 0, '0);
    rd_chk("R4 status idle", 3);

    // R7/R8: update word behaviour
    wr(2, 32'hABCD_0000);
    rd_chk("R7 rest bits", 2);
    rd_chk("R8 no request", 3);
    wr(2, 32'hABCD_0001);
    rd_chk("R8 request pending", 3);
    wr(2, 32'h1234_0000);
    rd_chk("R7 zero keeps request", 2);

    // R3: full transfer
    vs(0, 0, '0);
    rd_chk("R8 request cleared", 3);

    // Sweep protect patterns with and without a request (R5, R6, R9)
    for (int p = 0; p < (1 << NW); p++) begin
      for (int q = 0; q < 2; q++) begin
        fill(2 + p * 2 + q);
        wr(1, DW'(p));
        if (q != 0) wr(2, DW'(1));
        check_active("R9 before vsync");
        vs(0, 0, '0);
        rd_chk("R5 held status", 3);
        wr(1, 0);
        vs(0, 0, '0);
        rd_chk("R6 held cleared", 3);
        vs(0, 0, '0);
      end
    end

    // R7: set on the same clock as the vsync keeps the request
    fill(40);
    wr(2, DW'(1));
    vs(1, 2, DW'(1));
    rd_chk("R7 set wins over clear", 3);
    vs(0, 0, '0);
    rd_chk("R7 cleared afterwards", 3);

    // R11: unmapped addresses
    wr(4, 32'hDEAD_BEEF);
    wr(7, 32'hDEAD_BEEF);
    wr(20, 32'hDEAD_BEEF);
    wr(31, 32'hDEAD_BEEF);
    for (int a = 0; a < 32; a++) rd_chk("R11 map after stray writes", a);
    check_active("R11 active unchanged");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule